// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Change Interrupt

This block is the parallel I/O port of a small microcontroller. Software reaches it through a byte-wide register bus. There is one strobe that writes the output latches, one strobe that writes the direction register, and a port-read strobe. The port-read value is the level seen on the pads after synchronisation; it is never the latch contents. Each pad is modelled as three signals: a drive value, a drive enable and a sampled input.

Configuration inputs can take pins away from the port. A per-pin alternate-function mask removes any pin, and an external-oscillator select removes pins 4 and 5. A pin removed this way no longer drives and reads as 0. Pin 3 is input only. Pins 0, 1 and 3 share one weak pull-up enable. The same three pins feed a sticky change flag. That flag is raised when the synchronised level differs from the level captured at the last port read, and only while the change-interrupt enable is 1.

Top module: `gpio_port_ioc`

## Requirements
- R1: Bits 7:6 of both `rd_data` and `rd_dir` always read 0.
- R2: After a cycle with `rst` high, `rd_dir` is 8'h3F, `pad_oe` is 0, `pad_out` is 0 and `ioc_flag` is 0.
- R3: A cycle with `wr_dir_en` high loads `wdata[5:0]` into the direction bits from the next cycle. A direction bit of 1 means input and 0 means drive. `pad_oe[i]` is 1 exactly when direction bit i is 0 and the pin is owned by the port.
- R4: Pin 3 never drives (`pad_oe[3]`=0, `pad_out[3]`=0), and `rd_dir[3]` reads 1 whatever is written.
- R5: `rd_data[5:0]` shows the `pad_in` levels two clock edges after they are applied, through a two-stage synchroniser. It never shows the latch values.
- R6: Output latches load `wdata[5:0]` on `wr_data_en` and otherwise keep their value, including while the pin is an input. `pad_out[i]` equals latch i when `pad_oe[i]` is 1 and is 0 otherwise.
- R7: A pin whose `cfg_alt[i]` is 1 reads 0 in `rd_data` and has `pad_oe[i]`=0.
- R8: While `cfg_ext_osc` is 1, pins 4 and 5 read 0 and do not drive.
- R9: `pad_pu` is 6'b001011 when `pullup_en` is 1 and 0 otherwise.
- R10: Bit mask 6'b001011 selects pins 0, 1 and 3. `ioc_flag` is set at the edge after a cycle in which `ioc_en` is 1 and any selected bit of the read view (the `rd_data[5:0]` value) differs from the snapshot. The snapshot is loaded from the read view at every edge with `rd_strobe` high and resets to 0. The flag is never set while `ioc_en` is 0.
- R11: `ioc_flag` stays set until a cycle with `ioc_clr` high. It clears at that edge unless the set condition of R10 holds in the same cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_en | input | 1 | Write strobe for the output latches |
| wr_dir_en | input | 1 | Write strobe for the direction register |
| wdata | input | 8 | Write data byte |
| rd_strobe | input | 1 | Port read; captures the change-detect snapshot |
| rd_data | output | 8 | Port read value (synchronised pads) |
| rd_dir | output | 8 | Direction register readback |
| cfg_alt | input | 6 | Pins handed to alternate functions |
| cfg_ext_osc | input | 1 | External oscillator mode, claims pins 4 and 5 |
| pullup_en | input | 1 | Shared weak pull-up enable |
| ioc_en | input | 1 | Change-interrupt enable |
| ioc_clr | input | 1 | Clears the change flag |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad drive values |
| pad_oe | output | 6 | Pad drive enables |
| pad_pu | output | 6 | Weak pull-up enables |
| ioc_flag | output | 1 | Sticky change-interrupt flag |

## Verification
The bench tests the two-edge synchroniser latency. A design that is one stage short or one stage long shows `rd_data` changing a cycle early or late. It tests a latch written while the pin is an input, which a design that gates the write would lose, and writes of 0 to the direction bit of pin 3, which a design that stores that bit would turn into a driver. Pins taken by an alternate function or the oscillator must read 0 and release the pad, and a design that leaked them would show live levels. On the change flag, the bench covers the cycle where clear and a pending mismatch coincide, which an implementation with clear priority would drop. It also covers changes made while the enable is low, which an ungated flag would report.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W  = 8;
    localparam int NPIN    = 6;
    localparam int IN_ONLY = 3;
    localparam logic [NPIN-1:0] CHG_MASK = 6'b001011;
    localparam logic [NPIN-1:0] OSC_MASK = 6'b110000;

    typedef logic [NPIN-1:0]   pin_vec_t;
    typedef logic [PORT_W-1:0] byte_t;

    typedef struct packed {
        pin_vec_t oe;
        pin_vec_t out;
    } pad_drive_t;

    function automatic pin_vec_t claimed_pins(pin_vec_t alt, logic ext_osc);
        return alt | (ext_osc ? OSC_MASK : '0);
    endfunction

    function automatic byte_t widen(pin_vec_t v);
        return {{(PORT_W-NPIN){1'b0}}, v};
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

    generate
        if (STAGES >= 2) begin : g_chain_chk
            // R5
            sync_chain_chk: assert property (@(posedge clk) disable iff (rst)
                q == $past(stg[STAGES-2]));
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_data_en,
    input  logic       wr_dir_en,
    input  pin_vec_t   wdata,
    input  pin_vec_t   claimed,
    output pin_vec_t   dir_q,
    output pad_drive_t drive
);
    pin_vec_t lat_q;

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            if (i == IN_ONLY) begin : g_in
                assign dir_q[i] = 1'b1;
                assign lat_q[i] = 1'b0;
            end else begin : g_io
                logic d_r, l_r;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        d_r <= 1'b1;
                        l_r <= 1'b0;
                    end else begin
                        if (wr_dir_en)  d_r <= wdata[i];
                        if (wr_data_en) l_r <= wdata[i];
                    end
                end
                assign dir_q[i] = d_r;
                assign lat_q[i] = l_r;
            end
            assign drive.oe[i]  = ~dir_q[i] & ~claimed[i];
            assign drive.out[i] = drive.oe[i] & lat_q[i];
        end
    endgenerate

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_data_en |=> $stable(lat_q));
    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dir_en |=> dir_q == ($past(wdata) | pin_vec_t'(1 << IN_ONLY)));
    // R4
    in_only_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_dir_en && !wdata[IN_ONLY]) |=> dir_q[IN_ONLY]);
endmodule

// File: rtl/gpio_ioc.sv
module gpio_ioc
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t view,
    input  logic     rd_strobe,
    input  logic     ioc_en,
    input  logic     ioc_clr,
    output logic     flag
);
    pin_vec_t snap_q;
    logic     differs;
    logic     set_now;

    assign differs = |((view ^ snap_q) & CHG_MASK);
    assign set_now = ioc_en & differs;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            flag   <= 1'b0;
        end else begin
            if (rd_strobe) snap_q <= view & CHG_MASK;
            if (set_now)      flag <= 1'b1;
            else if (ioc_clr) flag <= 1'b0;
        end
    end

    // R10
    ioc_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_now |=> flag);
    // R10
    ioc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag && !ioc_en) |=> !flag);
    // R11
    ioc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !ioc_clr) |=> flag);
    // R11
    ioc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ioc_clr && !set_now) |=> !flag);
endmodule

// File: rtl/gpio_port_ioc.sv
module gpio_port_ioc
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_data_en,
    input  logic             wr_dir_en,
    input  logic [PORT_W-1:0] wdata,
    input  logic             rd_strobe,
    output logic [PORT_W-1:0] rd_data,
    output logic [PORT_W-1:0] rd_dir,
    input  logic [NPIN-1:0]  cfg_alt,
    input  logic             cfg_ext_osc,
    input  logic             pullup_en,
    input  logic             ioc_en,
    input  logic             ioc_clr,
    input  logic [NPIN-1:0]  pad_in,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe,
    output logic [NPIN-1:0]  pad_pu,
    output logic             ioc_flag
);
    pin_vec_t   claimed;
    pin_vec_t   sync_q;
    pin_vec_t   view;
    pin_vec_t   dir_q;
    pad_drive_t drive;

    assign claimed = claimed_pins(cfg_alt, cfg_ext_osc);

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_q)
    );

    gpio_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_data_en (wr_data_en),
        .wr_dir_en  (wr_dir_en),
        .wdata      (wdata[NPIN-1:0]),
        .claimed    (claimed),
        .dir_q      (dir_q),
        .drive      (drive)
    );

    assign view = sync_q & ~claimed;

    gpio_ioc u_ioc (
        .clk       (clk),
        .rst       (rst),
        .view      (view),
        .rd_strobe (rd_strobe),
        .ioc_en    (ioc_en),
        .ioc_clr   (ioc_clr),
        .flag      (ioc_flag)
    );

    assign rd_data = widen(view);
    assign rd_dir  = widen(dir_q);
    assign pad_out = drive.out;
    assign pad_oe  = drive.oe;
    assign pad_pu  = pullup_en ? CHG_MASK : '0;

    // R7
    alt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_data[NPIN-1:0] | pad_oe) & cfg_alt) == '0);
    // R8
    osc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_ext_osc |-> (((rd_data[NPIN-1:0] | pad_oe) & OSC_MASK) == '0));
    // R4
    in_only_pad_chk: assert property (@(posedge clk) disable iff (rst)
        !pad_oe[IN_ONLY] && !pad_out[IN_ONLY]);
endmodule

// File: tb/gpio_port_ioc_bench.sv
module gpio_port_ioc_bench;
    localparam int CLK_P = 10;
    localparam logic [5:0] CMASK = 6'b001011;

    logic clk = 1'b0;
    logic rst, wr_data_en, wr_dir_en, rd_strobe, cfg_ext_osc, pullup_en, ioc_en, ioc_clr;
    logic [7:0] wdata, rd_data, rd_dir;
    logic [5:0] cfg_alt, pad_in, pad_out, pad_oe, pad_pu;
    logic ioc_flag;

    int n_chk = 0;
    int n_err = 0;

    logic [5:0] m_dir, m_lat, m_s1, m_s2, m_snap;
    logic       m_flag;

    always #(CLK_P/2) clk = ~clk;

    gpio_port_ioc u_gpio_port_ioc (
        .clk(clk), .rst(rst), .wr_data_en(wr_data_en), .wr_dir_en(wr_dir_en),
        .wdata(wdata), .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_dir(rd_dir),
        .cfg_alt(cfg_alt), .cfg_ext_osc(cfg_ext_osc), .pullup_en(pullup_en),
        .ioc_en(ioc_en), .ioc_clr(ioc_clr), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .ioc_flag(ioc_flag)
    );

    function automatic logic [5:0] f_claim();
        return cfg_alt | (cfg_ext_osc ? 6'b110000 : 6'b0);
    endfunction
    function automatic logic [5:0] f_view();
        return m_s2 & ~f_claim();
    endfunction
    function automatic logic [5:0] f_oe();
        return ~m_dir & ~f_claim() & 6'b110111;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        check("R5 rd_data", rd_data, {2'b00, f_view()});
        check("R3 pad_oe", {2'b00, pad_oe}, {2'b00, f_oe()});
        check("R6 pad_out", {2'b00, pad_out}, {2'b00, f_oe() & m_lat});
        check("R4 rd_dir", rd_dir, {2'b00, m_dir | 6'b001000});
        check("R9 pad_pu", {2'b00, pad_pu}, {2'b00, pullup_en ? CMASK : 6'b0});
        check("R10 ioc_flag", {7'b0, ioc_flag}, {7'b0, m_flag});
    endtask

    task automatic tick();
        logic [5:0] v;
        logic       mism;
        @(posedge clk);
        if (rst) begin
            m_dir = 6'h3F; m_lat = '0; m_s1 = '0; m_s2 = '0; m_snap = '0; m_flag = 1'b0;
        end else begin
            v    = f_view();
            mism = |((v ^ m_snap) & CMASK);
            if (ioc_en && mism) m_flag = 1'b1;
            else if (ioc_clr)   m_flag = 1'b0;
            if (rd_strobe)  m_snap = v & CMASK;
            if (wr_dir_en)  m_dir  = wdata[5:0] | 6'b001000;
            if (wr_data_en) m_lat  = wdata[5:0] & 6'b110111;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
        @(negedge clk);
    endtask

    task automatic step();
        #1;
        check_all();
        tick();
    endtask

    task automatic idle();
        wr_data_en = 0; wr_dir_en = 0; rd_strobe = 0; ioc_clr = 0; wdata = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h0000_5EED);
        rst = 1; idle(); cfg_alt = '0; cfg_ext_osc = 0; pullup_en = 0; ioc_en = 0; pad_in = '0;
        @(negedge clk);
        tick(); tick(); tick();
        rst = 0;
        #1;
        // R2 reset state
        check("R2 rd_dir", rd_dir, 8'h3F);
        check("R2 pad_oe", {2'b0, pad_oe}, 8'h00);
        check("R2 pad_out", {2'b0, pad_out}, 8'h00);
        check("R2 ioc_flag", {7'b0, ioc_flag}, 8'h00);
        step();

        // R6 latch written while pins are inputs, then revealed; R4 pin 3 write of 0
        wr_data_en = 1; wdata = 8'hFF; step(); idle();
        check("R6 hidden", {2'b0, pad_oe}, 8'h00);
        wr_dir_en = 1; wdata = 8'hC0; step(); idle();
        #1;
        check("R4 rd_dir3", {7'b0, rd_dir[3]}, 8'h01);
        check("R1 rd_dir top", {6'b0, rd_dir[7:6]}, 8'h00);
        check("R6 revealed", {2'b0, pad_out}, 8'h37);
        step();

        // R5 latency and read of pads not latches
        pad_in = 6'b101010; step();
        check("R5 one edge", rd_data, 8'h00);
        step();
        #1;
        check("R5 two edges", rd_data, 8'h2A);
        check("R1 rd_data top", {6'b0, rd_data[7:6]}, 8'h00);
        step();

        // R7 alternate function on pin 1 and pin 0
        cfg_alt = 6'b000011; #1;
        check("R7 read zero", {6'b0, rd_data[1:0]}, 8'h00);
        check("R7 no drive", {6'b0, pad_oe[1:0]}, 8'h00);
        step(); cfg_alt = '0;

        // R8 oscillator claims pins 4 and 5
        pad_in = 6'b110000; step(); step();
        cfg_ext_osc = 1; #1;
        check("R8 read zero", {6'b0, rd_data[5:4]}, 8'h00);
        check("R8 no drive", {6'b0, pad_oe[5:4]}, 8'h00);
        step(); cfg_ext_osc = 0;

        // R10 gated change, then enabled change
        rd_strobe = 1; step(); idle();
        pad_in = 6'b110001; step(); step(); step();
        check("R10 gated", {7'b0, ioc_flag}, 8'h00);
        ioc_en = 1; step();
        check("R10 set", {7'b0, ioc_flag}, 8'h01);
        // R11 clear with pending mismatch: stays set
        ioc_clr = 1; step(); idle();
        check("R11 clear lost to set", {7'b0, ioc_flag}, 8'h01);
        rd_strobe = 1; step(); idle();
        ioc_clr = 1; step(); idle();
        check("R11 cleared", {7'b0, ioc_flag}, 8'h00);
        step();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            wr_data_en  = ($urandom % 4) == 0;
            wr_dir_en   = ($urandom % 5) == 0;
            wdata       = 8'($urandom);
            rd_strobe   = ($urandom % 6) == 0;
            ioc_clr     = ($urandom % 7) == 0;
            ioc_en      = ($urandom % 4) != 0;
            pullup_en   = 1'($urandom);
            cfg_alt     = (($urandom % 8) == 0) ? 6'($urandom) : 6'b0;
            cfg_ext_osc = ($urandom % 10) == 0;
            if (($urandom % 3) == 0) pad_in = 6'($urandom);
            step();
        end
        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule